// File: doc/BRIEF.md
# Overlay Window Fetch Address Generator

This block follows one overlay window across the active display raster and turns the pixels that fall inside it into a stream of word fetch addresses. A timing generator supplies the current pixel column, line and a valid strobe. Software supplies the window's top-left and bottom-right corners, the buffer start and end addresses, the byte length of one window line, the bytes to skip between lines and the pixel depth. The window is a sub-rectangle of a larger framebuffer. After the last word of each window line, the address jumps over the part of the framebuffer row that lies outside the window.

Inside the window, every pixel adds its storage width to a bit accumulator. Each filled memory word becomes one pending fetch, and the last pixel of a window line always closes a partial word. Pending fetches are presented on a request/ready handshake, and the address moves on only when a request is accepted. The address reloads at the window's top-left pixel of each frame. Fetching stops for the rest of the frame once the next address would reach the programmed end address, and an end-of-buffer flag reports this.

Top module: `ovw_addr_gen`

## Requirements
- R1: `in_win` is 1 in the cycle after a pixel with `pix_valid`=1 whose column lies within `win_tl_x`..`win_br_x` and whose line lies within `win_tl_y`..`win_br_y`, both ends inclusive. It is 0 in the cycle after any other pixel, including pixels presented with `pix_valid`=0.
- R2: `pix_depth` gives the bits per pixel. The values 1, 2, 4, 8, 16 and 32 are used as given. The value 24, and any value not in this list, is stored unpacked in a 32-bit slot.
- R3: Each accumulation of WORD_BITS (default 32) pixel bits inside the window produces exactly one fetch. The last window pixel of a line (column `win_br_x`) produces one more fetch if the word is only partly filled. The count of pending fetches never overflows.
- R4: Successive accepted addresses in a window line step by WORD_BITS/8 bytes. After the word that completes `line_bytes`, the next address is that line's first address plus `line_bytes` plus `line_skip`.
- R5: At the window's top-left pixel, the address reloads to `buf_start`, `buf_done` clears and any pending fetches of the earlier frame are dropped.
- R6: While `fetch_req` is 1 and `fetch_ready` is 0, `fetch_req` stays 1 and `fetch_addr` stays unchanged. The address advances only on an accepted request.
- R7: If the address following an accepted word is at or above `buf_end`, `buf_done` rises and stays 1, and no further request is made until the next restart.
- R8: After reset, `fetch_req`, `in_win` and `buf_done` are 0.
- R9: With `buf_end` = `buf_start` + framebuffer row bytes × window height, every word of the window is fetched, and `buf_done` rises after the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Current raster position is an active pixel |
| pix_x | input | CW | Raster column |
| pix_y | input | CW | Raster line |
| win_tl_x | input | CW | Window left column (inclusive) |
| win_tl_y | input | CW | Window top line (inclusive) |
| win_br_x | input | CW | Window right column (inclusive) |
| win_br_y | input | CW | Window bottom line (inclusive) |
| buf_start | input | ADDR_W | Byte address of the window's first pixel |
| buf_end | input | ADDR_W | Byte address bounding the frame's fetches |
| line_bytes | input | LB_W | Bytes fetched per window line |
| line_skip | input | LB_W | Bytes skipped after each window line |
| pix_depth | input | 6 | Bits per pixel (see R2) |
| fetch_ready | input | 1 | Memory side accepts the request |
| in_win | output | 1 | Previous pixel lay inside the window |
| fetch_req | output | 1 | Fetch request |
| fetch_addr | output | ADDR_W | Byte address of the requested word |
| buf_done | output | 1 | End of buffer reached this frame |

## Verification
The assertions rest on several assumptions about the inputs. The window and buffer settings must stay constant during a frame. `line_bytes` and `line_skip` must be word multiples that agree with the window width and depth. The memory side must accept requests often enough that the pending count never saturates. The stimulus changes the configuration only between frames, while the raster is idle. It uses narrow windows whose pending words drain within the horizontal blanking, holds `fetch_ready` low one cycle in three, and lets every backlog drain before the next frame starts.

// File: rtl/ovw_pkg.sv
package ovw_pkg;

  localparam int DEPTH_W = 6;

  // Storage bits occupied by one pixel of the given depth.
  function automatic logic [DEPTH_W-1:0] slot_bits(input logic [DEPTH_W-1:0] depth);
    logic [DEPTH_W-1:0] r;
    case (depth)
      6'd1, 6'd2, 6'd4, 6'd8, 6'd16, 6'd32: r = depth;
      default:                              r = 6'd32;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ovw_win_detect.sv
module ovw_win_detect #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic [CW-1:0] tl_x,
  input  logic [CW-1:0] tl_y,
  input  logic [CW-1:0] br_x,
  input  logic [CW-1:0] br_y,
  output logic          hit,
  output logic          first_pix,
  output logic          last_pix,
  output logic          in_win
);

  logic in_win_n;

  always_comb begin
    hit       = pix_valid && (pix_x >= tl_x) && (pix_x <= br_x) &&
                (pix_y >= tl_y) && (pix_y <= br_y);
    first_pix = hit && (pix_x == tl_x) && (pix_y == tl_y);
    last_pix  = hit && (pix_x == br_x);
    in_win_n  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_win <= 1'b0;
    else        in_win <= in_win_n;
  end

endmodule

// File: rtl/ovw_word_pacer.sv
module ovw_word_pacer
  import ovw_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int OWE_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic               first_pix,
  input  logic               last_pix,
  input  logic [DEPTH_W-1:0] bits,
  input  logic               take,
  input  logic               done,
  output logic               inc,
  output logic [OWE_W-1:0]   owed,
  output logic               owed_nz
);

  localparam int ACC_W = $clog2(WORD_BITS) + 2;
  localparam logic [OWE_W-1:0] OWE_MAX = '1;

  logic [ACC_W-1:0] acc, acc_n, acc_base, acc_sum;
  logic [OWE_W-1:0] owed_n, owed_dec;
  logic             full;

  always_comb begin
    acc_base = first_pix ? '0 : acc;
    acc_sum  = acc_base + {{(ACC_W-DEPTH_W){1'b0}}, bits};
    full     = acc_sum >= ACC_W'(WORD_BITS);
    inc      = hit && (full || last_pix);
    acc_n    = acc;
    if (hit) acc_n = (full || last_pix) ? '0 : acc_sum;

    owed_dec = (take && (owed != '0)) ? owed - 1'b1 : owed;
    if (first_pix)     owed_n = inc ? OWE_W'(1) : '0;
    else if (done)     owed_n = '0;
    else if (inc && owed_dec != OWE_MAX) owed_n = owed_dec + 1'b1;
    else               owed_n = owed_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      owed <= '0;
    end else begin
      acc  <= acc_n;
      owed <= owed_n;
    end
  end

  assign owed_nz = owed != '0;

endmodule

// File: rtl/ovw_addr_walker.sv
module ovw_addr_walker #(
  parameter int ADDR_W     = 32,
  parameter int LB_W       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              take,
  input  logic [ADDR_W-1:0] buf_start,
  input  logic [ADDR_W-1:0] buf_end,
  input  logic [LB_W-1:0]   line_bytes,
  input  logic [LB_W-1:0]   line_skip,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  logic [ADDR_W-1:0] line_base, line_base_n, addr_n, step_addr;
  logic [LB_W-1:0]   off, off_n;
  logic [LB_W:0]     off_step;
  logic              done_n, line_last;

  always_comb begin
    off_step  = {1'b0, off} + (LB_W+1)'(WORD_BYTES);
    line_last = off_step >= {1'b0, line_bytes};
    step_addr = line_last
              ? line_base + {{(ADDR_W-LB_W){1'b0}}, line_bytes}
                          + {{(ADDR_W-LB_W){1'b0}}, line_skip}
              : addr + ADDR_W'(WORD_BYTES);
    line_base_n = line_base;
    off_n       = off;
    addr_n      = addr;
    done_n      = done;
    if (restart) begin
      line_base_n = buf_start;
      addr_n      = buf_start;
      off_n       = '0;
      done_n      = buf_start >= buf_end;
    end else if (take) begin
      if (line_last) begin
        line_base_n = step_addr;
        off_n       = '0;
      end else begin
        off_n = off_step[LB_W-1:0];
      end
      addr_n = step_addr;
      if (step_addr >= buf_end) done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_base <= '0;
      addr      <= '0;
      off       <= '0;
      done      <= 1'b0;
    end else begin
      line_base <= line_base_n;
      addr      <= addr_n;
      off       <= off_n;
      done      <= done_n;
    end
  end

endmodule

// File: rtl/ovw_addr_gen.sv
module ovw_addr_gen
  import ovw_pkg::*;
#(
  parameter int CW        = 12,
  parameter int ADDR_W    = 32,
  parameter int LB_W      = 16,
  parameter int WORD_BITS = 32,
  parameter int OWE_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  input  logic [CW-1:0]      pix_x,
  input  logic [CW-1:0]      pix_y,
  input  logic [CW-1:0]      win_tl_x,
  input  logic [CW-1:0]      win_tl_y,
  input  logic [CW-1:0]      win_br_x,
  input  logic [CW-1:0]      win_br_y,
  input  logic [ADDR_W-1:0]  buf_start,
  input  logic [ADDR_W-1:0]  buf_end,
  input  logic [LB_W-1:0]    line_bytes,
  input  logic [LB_W-1:0]    line_skip,
  input  logic [DEPTH_W-1:0] pix_depth,
  input  logic               fetch_ready,
  output logic               in_win,
  output logic               fetch_req,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic               buf_done
);

  localparam int WORD_BYTES = WORD_BITS / 8;

  logic               hit, first_pix, last_pix, inc, owed_nz, take;
  logic [OWE_W-1:0]   owed;
  logic [DEPTH_W-1:0] bits;

  assign bits      = slot_bits(pix_depth);
  assign fetch_req = owed_nz && !buf_done;
  assign take      = fetch_req && fetch_ready;

  ovw_win_detect #(.CW(CW)) u_detect (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y),
    .tl_x(win_tl_x), .tl_y(win_tl_y), .br_x(win_br_x), .br_y(win_br_y),
    .hit(hit), .first_pix(first_pix), .last_pix(last_pix), .in_win(in_win)
  );

  ovw_word_pacer #(.WORD_BITS(WORD_BITS), .OWE_W(OWE_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .hit(hit), .first_pix(first_pix),
    .last_pix(last_pix), .bits(bits), .take(take), .done(buf_done),
    .inc(inc), .owed(owed), .owed_nz(owed_nz)
  );

  ovw_addr_walker #(.ADDR_W(ADDR_W), .LB_W(LB_W), .WORD_BYTES(WORD_BYTES)) u_walker (
    .clk(clk), .rst_n(rst_n), .restart(first_pix), .take(take),
    .buf_start(buf_start), .buf_end(buf_end),
    .line_bytes(line_bytes), .line_skip(line_skip),
    .addr(fetch_addr), .done(buf_done)
  );

endmodule

module ovw_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int OWE_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              first_pix,
  input logic              inc,
  input logic              take,
  input logic [OWE_W-1:0]  owed,
  input logic              fetch_req,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] buf_start,
  input logic [ADDR_W-1:0] buf_end,
  input logic              buf_done
);

  // R3: the pending-fetch count must never need to exceed its range
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((&owed) && !first_pix && !buf_done) |-> !(inc && !take));

  // R5: restart reloads the start address
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    first_pix |=> (fetch_addr == $past(buf_start)));

  // R6: a stalled request holds with its address
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ready && !first_pix) |=> (fetch_req && $stable(fetch_addr)));

  // R7: end-of-buffer is sticky until restart
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && !first_pix) |=> buf_done);

  // R7: no request ever reaches the end address
  assert_addr_below_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (fetch_addr < buf_end));

endmodule

bind ovw_addr_gen ovw_addr_gen_chk #(.ADDR_W(ADDR_W), .OWE_W(OWE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .first_pix(first_pix), .inc(inc), .take(take),
  .owed(owed), .fetch_req(fetch_req), .fetch_ready(fetch_ready),
  .fetch_addr(fetch_addr), .buf_start(buf_start), .buf_end(buf_end),
  .buf_done(buf_done)
);

// File: tb/tb_ovw_addr_gen.sv
module tb_ovw_addr_gen;

  localparam int CW = 12, ADDR_W = 32, LB_W = 16;
  localparam int H_TOT = 56, V_TOT = 14, H_ACT = 48, V_ACT = 12;

  logic              clk, rst_n, pix_valid, fetch_ready;
  logic [CW-1:0]     pix_x, pix_y, win_tl_x, win_tl_y, win_br_x, win_br_y;
  logic [ADDR_W-1:0] buf_start, buf_end, fetch_addr;
  logic [LB_W-1:0]   line_bytes, line_skip;
  logic [5:0]        pix_depth;
  logic              in_win, fetch_req, buf_done;

  ovw_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .win_tl_x(win_tl_x), .win_tl_y(win_tl_y), .win_br_x(win_br_x), .win_br_y(win_br_y),
    .buf_start(buf_start), .buf_end(buf_end), .line_bytes(line_bytes),
    .line_skip(line_skip), .pix_depth(pix_depth), .fetch_ready(fetch_ready),
    .in_win(in_win), .fetch_req(fetch_req), .fetch_addr(fetch_addr), .buf_done(buf_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0, checks = 0, rdy_cnt = 0;
  bit mon_en = 0, prev_stall = 0;
  logic [ADDR_W-1:0] prev_addr;
  logic [ADDR_W-1:0] expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: samples 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (mon_en) begin
        if (prev_stall) begin
          chk(fetch_req && fetch_addr == prev_addr, "R6", "stalled request held",
              fetch_addr, prev_addr);
        end
        if (fetch_req && fetch_ready) begin
          if (expq.size() == 0) chk(0, "R3", "unexpected fetch", fetch_addr, 0);
          else begin
            logic [ADDR_W-1:0] e;
            e = expq.pop_front();
            chk(fetch_addr == e, "R4", "fetch address", fetch_addr, e);
          end
        end
        prev_stall = fetch_req && !fetch_ready;
        prev_addr  = fetch_addr;
      end
    end
  end

  // Expected address list of one frame; returns whether the end is reached
  task automatic gen_expect(input longint st, input longint lb, input longint sk,
                            input longint en, input int h, output bit stop);
    int nw;
    nw   = int'(lb / 4);
    stop = 0;
    for (int j = 0; j < h; j++) begin
      for (int w = 0; w < nw; w++) begin
        if (!stop) begin
          longint a, nx;
          a  = st + j * (lb + sk) + w * 4;
          expq.push_back(a[ADDR_W-1:0]);
          nx = (w == nw - 1) ? st + (j + 1) * (lb + sk) : a + 4;
          if (nx >= en) stop = 1;
        end
      end
    end
  endtask

  task automatic drive_pix(input bit v, input int x, input int y, inout bit exp_prev,
                           input string tag);
    @(negedge clk);
    chk(in_win == exp_prev, "R1", {"in_win ", tag}, in_win, exp_prev);
    pix_valid   = v;
    pix_x       = CW'(x);
    pix_y       = CW'(y);
    fetch_ready = (rdy_cnt % 3) != 2;
    rdy_cnt++;
    exp_prev = v && x >= int'(win_tl_x) && x <= int'(win_br_x) &&
               y >= int'(win_tl_y) && y <= int'(win_br_y);
  endtask

  task automatic run_frame(input string tag, input int tx, input int ty, input int w,
                           input int h, input int depth, input int bpp8x,
                           input int fbw, input longint st, input longint en_over);
    bit stop, ew;
    longint lb, sk, en;
    lb = (w * bpp8x) / 8;
    sk = ((fbw - w) * bpp8x) / 8;
    en = (en_over != 0) ? en_over : st + (lb + sk) * h;
    @(negedge clk);
    win_tl_x = CW'(tx); win_tl_y = CW'(ty);
    win_br_x = CW'(tx + w - 1); win_br_y = CW'(ty + h - 1);
    buf_start = st[ADDR_W-1:0]; buf_end = en[ADDR_W-1:0];
    line_bytes = lb[LB_W-1:0]; line_skip = sk[LB_W-1:0];
    pix_depth = 6'(depth);
    gen_expect(st, lb, sk, en, h, stop);
    ew = 0;
    for (int y = 0; y < V_TOT; y++)
      for (int x = 0; x < H_TOT; x++)
        drive_pix(x < H_ACT && y < V_ACT, x, y, ew, tag);
    // R1: window coordinates with valid low must not count
    for (int i = 0; i < 40; i++) drive_pix(0, tx, ty, ew, tag);
    chk(expq.size() == 0, "R9", {"all words fetched ", tag}, expq.size(), 0);
    expq.delete();
    chk(buf_done == stop, "R7", {"buf_done ", tag}, buf_done, stop);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; pix_valid = 0; pix_x = '0; pix_y = '0; fetch_ready = 0;
    win_tl_x = '0; win_tl_y = '0; win_br_x = '0; win_br_y = '0;
    buf_start = '0; buf_end = '0; line_bytes = '0; line_skip = '0; pix_depth = 6'd32;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(fetch_req == 0, "R8", "reset fetch_req", fetch_req, 0);
    chk(in_win == 0, "R8", "reset in_win", in_win, 0);
    chk(buf_done == 0, "R8", "reset buf_done", buf_done, 0);
    mon_en = 1;
    // 32 bpp, window inside, full-frame end (R9)
    run_frame("R9 32bpp", 3, 2, 4, 4, 32, 32, 10, 32'h1000, 0);
    // 8 bpp at raster origin, end far away: no end reached (R3 R4)
    run_frame("R3 8bpp", 0, 0, 8, 3, 8, 8, 20, 32'h2000, 32'h3000);
    // 16 bpp at bottom-right raster edge, inclusive corners (R1)
    run_frame("R1 16bpp", 42, 9, 6, 3, 16, 16, 16, 32'h3000, 0);
    // 24 bpp stored in 32-bit slots (R2)
    run_frame("R2 24bpp", 10, 4, 2, 2, 24, 32, 5, 32'h4000, 0);
    // unknown depth 12 treated as 32-bit slots (R2)
    run_frame("R2 unknown", 20, 6, 3, 2, 12, 32, 4, 32'h4100, 0);
    // 1 bpp: one word per line (R3)
    run_frame("R3 1bpp", 8, 1, 32, 2, 1, 1, 64, 32'h5000, 0);
    // 4 bpp: one word per line (R3)
    run_frame("R3 4bpp", 30, 3, 8, 4, 4, 4, 16, 32'h5100, 0);
    // truncated end: stop mid-frame (R7), then restart reloads (R5)
    run_frame("R7 cut", 3, 2, 4, 4, 32, 32, 10, 32'h6000, 32'h6028);
    run_frame("R5 restart", 3, 2, 4, 4, 32, 32, 10, 32'h7000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule